// File: doc/BRIEF.md
# SONET Payload Envelope Marker

This block sits in the receive path of a 32-bit STS-48 SONET stream. Each clock carries one word of four byte-interleaved STS-1 bytes, and a single-cycle pulse flags the first word of every frame. The block tracks where each word sits in the frame and delays the data by two registers. Beside the data it drives a four-bit mask, one bit per byte, that separates payload from transport overhead. It also passes on a delayed copy of the frame pulse.

When justification tracking is switched on, the block reads the ten-bit pointer carried in the H1/H2 overhead bytes of every STS-1. It compares that pointer with the one kept from the previous frame. It uses only the increment and decrement bit groups to decide whether that STS-1 shifts its payload by one byte in the current frame. The marking of the H3 byte and of the byte after it is then adjusted for that STS-1 alone. The block does not check, move or otherwise interpret pointer values, and it ignores the new-data flag.

Top module: `spe_indicator_gen`

## Requirements
- R1: A frame is 9 rows of 1080 words. Words 0 to 35 of a row are overhead and words 36 to 1079 are payload. Without a new frame pulse, the position wraps from the last word of row 8 to row 0, word 0.
- R2: A pulse on `fp_in` places the word on which it arrives at row 0, word 0, whatever position the counters hold. Early and late pulses are both accepted without error.
- R3: Outside the H3 window, every mask bit is 0 for an overhead word and 1 for a payload word.
- R4: `data_out` and `fp_out` equal `data_in` and `fp_in` from two clocks earlier, aligned with the mask for that word. While `rst` is high, all three outputs are held at zero.
- R5: While `just_en` is low, no justification is ever decided. H3 bytes are marked 0 and the bytes after H3 are marked 1.
- R6: An increment (positive justification) is decided when at least 3 of the pointer bits 9, 7, 5, 3 and 1 differ from the stored pointer and fewer than 3 of bits 8, 6, 4, 2 and 0 differ. That STS-1's H3 byte and the byte after it are then both marked 0.
- R7: A decrement (negative justification) is decided when at least 3 of bits 8, 6, 4, 2 and 0 differ and fewer than 3 of bits 9, 7, 5, 3 and 1 differ. That STS-1's H3 byte and the byte after it are then both marked 1.
- R8: When both bit groups or neither reach 3 differences, no justification is decided: H3 is marked 0 and the byte after it 1. The stored pointer of an STS-1 is replaced by the received one only in this case.
- R9: All pointer and H3 handling uses zero-based row 3. Byte b of a word (b=0 is bits 31:24) in word w belongs to STS-1 number 4*(w mod 12)+b. Words 0 to 11 carry H1, words 12 to 23 carry H2, words 24 to 35 carry H3, and words 36 to 47 carry the byte after H3. Pointer bits 9:8 are H1 bits 1:0, and pointer bits 7:0 are the H2 byte. A decision applies to the H3 window of the same row of the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| just_en | input | 1 | Enables justification tracking |
| data_in | input | 32 | Received word, four interleaved STS-1 bytes, first byte in bits 31:24 |
| fp_in | input | 1 | High on the first word of a frame |
| data_out | output | 32 | Received word, delayed two clocks |
| fp_out | output | 1 | Frame pulse, delayed two clocks |
| spe_out | output | 4 | Payload mask, bit 3 for bits 31:24 down to bit 0 for bits 7:0 |

## Verification
The assertions take for granted that `fp_in` comes as a one-cycle pulse, so that a restart is followed by ordinary word-by-word counting. They also assume that pointer-derived flags only change state in H2 words of row 3. The stimulus holds `just_en` steady for a whole frame and builds every received pointer from the model's stored pointer, XORed with a chosen mask. The expected decision therefore follows from the requirement alone. Frames are sent back to back with one pulse each. The only exceptions are the deliberate early pulse, and the late case where the stream runs 15 words past the frame end before its pulse arrives.

// File: rtl/spe_pkg.sv
package spe_pkg;

  typedef enum logic [1:0] {
    JUST_NONE = 2'd0,
    JUST_INC  = 2'd1,
    JUST_DEC  = 2'd2
  } just_e;

  localparam int PTR_W    = 10;
  localparam int VOTE_MIN = 3;

  // Majority vote on inverted bits: odd positions vote increment, even vote decrement.
  function automatic just_e classify(input logic [PTR_W-1:0] old_p,
                                     input logic [PTR_W-1:0] new_p);
    logic [PTR_W-1:0] flip;
    int n_inc;
    int n_dec;
    flip  = old_p ^ new_p;
    n_inc = 0;
    n_dec = 0;
    for (int k = 0; k < PTR_W / 2; k++) begin
      n_inc += int'(flip[2*k+1]);
      n_dec += int'(flip[2*k]);
    end
    if (n_inc >= VOTE_MIN && n_dec < VOTE_MIN) return JUST_INC;
    if (n_dec >= VOTE_MIN && n_inc < VOTE_MIN) return JUST_DEC;
    return JUST_NONE;
  endfunction

endpackage

// File: rtl/spe_frame_counter.sv
module spe_frame_counter #(
  parameter int ROWS      = 9,
  parameter int WORDS_ROW = 1080,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_in,
  output logic [ROW_W-1:0] row_now,
  output logic [COL_W-1:0] col_now
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(WORDS_ROW - 1);
  localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);

  logic [ROW_W-1:0] row_nxt_q;
  logic [COL_W-1:0] col_nxt_q;

  // The pulse overrides the predicted position of the current word.
  always_comb begin
    row_now = fp_in ? '0 : row_nxt_q;
    col_now = fp_in ? '0 : col_nxt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_nxt_q <= '0;
      col_nxt_q <= '0;
    end else if (col_now == COL_LAST) begin
      col_nxt_q <= '0;
      row_nxt_q <= (row_now == ROW_LAST) ? '0 : row_now + 1'b1;
    end else begin
      col_nxt_q <= col_now + 1'b1;
      row_nxt_q <= row_now;
    end
  end

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (col_now <= COL_LAST) && (row_now <= ROW_LAST)); // R1

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (row_now == ROW_LAST && col_now == COL_LAST) |=>
      (row_now == '0 && col_now == '0)); // R1

  AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (rst)
    fp_in |=> (fp_in || (row_now == '0 && col_now == COL_ONE))); // R2

endmodule

// File: rtl/spe_ptr_tracker.sv
module spe_ptr_tracker
  import spe_pkg::*;
#(
  parameter int N_STS   = 48,
  parameter int BYTES   = 4,
  parameter int PTR_ROW = 3,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 11
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        just_en,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [COL_W-1:0]            col_i,
  input  logic [8*BYTES-1:0]          data_i,
  output logic [N_STS-1:0][1:0]       codes_o
);

  localparam int GROUPS = N_STS / BYTES;
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [ROW_W-1:0] PTR_R  = ROW_W'(PTR_ROW);
  localparam logic [COL_W-1:0] H2_COL = COL_W'(GROUPS);
  localparam logic [COL_W-1:0] H3_COL = COL_W'(2 * GROUPS);

  logic                      in_h1, in_h2;
  logic [GRP_W-1:0]          grp;
  logic [BYTES-1:0][7:0]     bytes;
  logic [2*BYTES-1:0]        h1_rd;
  logic [PTR_W*BYTES-1:0]    prev_rd;
  logic [BYTES-1:0][PTR_W-1:0] new_ptr;
  logic [BYTES-1:0][1:0]     dec;
  logic [BYTES-1:0]          wr_b;
  logic [N_STS-1:0][1:0]     code_q;

  // H1 low bits waiting for their H2 partner, and last accepted pointers.
  logic [2*BYTES-1:0]        h1_mem   [GROUPS];
  logic [PTR_W*BYTES-1:0]    prev_mem [GROUPS];

  assign in_h1 = (row_i == PTR_R) && (col_i < H2_COL);
  assign in_h2 = (row_i == PTR_R) && (col_i >= H2_COL) && (col_i < H3_COL);
  assign grp   = in_h2 ? GRP_W'(col_i - H2_COL) : GRP_W'(col_i);

  assign h1_rd   = h1_mem[grp];
  assign prev_rd = prev_mem[grp];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign bytes[b]   = data_i[8*(BYTES-1-b) +: 8];
    assign new_ptr[b] = {h1_rd[2*b +: 2], bytes[b]};
    assign dec[b]     = just_en ? classify(prev_rd[PTR_W*b +: PTR_W], new_ptr[b])
                                : JUST_NONE;
    assign wr_b[b]    = in_h2 && (dec[b] == JUST_NONE);
  end

  always_ff @(posedge clk) begin
    if (in_h1) begin
      for (int b = 0; b < BYTES; b++) begin
        h1_mem[grp][2*b +: 2] <= bytes[b][1:0];
      end
    end
  end

  // Byte-enabled write: only lanes without a justification refresh history.
  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (wr_b[b]) prev_mem[grp][PTR_W*b +: PTR_W] <= new_ptr[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (in_h2) begin
      for (int i = 0; i < N_STS; i++) begin
        if (GRP_W'(i / BYTES) == grp) code_q[i] <= dec[i % BYTES];
      end
    end
  end

  assign codes_o = code_q;

  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_h2 |=> $stable(code_q)); // R9

endmodule

// File: rtl/spe_mask_gen.sv
module spe_mask_gen
  import spe_pkg::*;
#(
  parameter int N_STS   = 48,
  parameter int BYTES   = 4,
  parameter int PTR_ROW = 3,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [N_STS-1:0][1:0] codes_i,
  output logic [BYTES-1:0]      mask_o
);

  localparam int GROUPS = N_STS / BYTES;
  localparam int STS_W  = (N_STS > 1) ? $clog2(N_STS) : 1;
  localparam logic [ROW_W-1:0] PTR_R   = ROW_W'(PTR_ROW);
  localparam logic [COL_W-1:0] H3_COL  = COL_W'(2 * GROUPS);
  localparam logic [COL_W-1:0] TOH_END = COL_W'(3 * GROUPS);
  localparam logic [COL_W-1:0] AFT_END = COL_W'(4 * GROUPS);

  logic             in_row, in_h3, in_aft;
  logic [BYTES-1:0] mask_d;

  assign in_row = (row_i == PTR_R);
  assign in_h3  = in_row && (col_i >= H3_COL) && (col_i < TOH_END);
  assign in_aft = in_row && (col_i >= TOH_END) && (col_i < AFT_END);

  for (genvar b = 0; b < BYTES; b++) begin : g_bit
    logic [STS_W-1:0] h3_idx, aft_idx;
    logic [1:0]       h3_code, aft_code;
    assign h3_idx   = STS_W'(col_i - H3_COL) * STS_W'(BYTES) + STS_W'(b);
    assign aft_idx  = STS_W'(col_i - TOH_END) * STS_W'(BYTES) + STS_W'(b);
    assign h3_code  = codes_i[h3_idx];
    assign aft_code = codes_i[aft_idx];
    // Output bit order: bit BYTES-1 marks the first (most significant) byte.
    always_comb begin
      if (in_h3)              mask_d[BYTES-1-b] = (h3_code == JUST_DEC);
      else if (in_aft)        mask_d[BYTES-1-b] = (aft_code != JUST_INC);
      else if (col_i < TOH_END) mask_d[BYTES-1-b] = 1'b0;
      else                    mask_d[BYTES-1-b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else     mask_o <= mask_d;
  end

  AST_TOH_DARK: assert property (@(posedge clk) disable iff (rst)
    (col_i < TOH_END && !in_h3) |=> (mask_o == '0)); // R3

  AST_PAYLOAD_LIT: assert property (@(posedge clk) disable iff (rst)
    (col_i >= AFT_END || (col_i >= TOH_END && !in_row)) |=> (&mask_o)); // R3

endmodule

// File: rtl/spe_indicator_gen.sv
module spe_indicator_gen
  import spe_pkg::*;
#(
  parameter int N_STS     = 48,
  parameter int BYTES     = 4,
  parameter int ROWS      = 9,
  parameter int PTR_ROW   = 3,
  parameter int TOH_COLS  = 3,
  parameter int SPE_COLS  = 87
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 just_en,
  input  logic [8*BYTES-1:0]   data_in,
  input  logic                 fp_in,
  output logic [8*BYTES-1:0]   data_out,
  output logic                 fp_out,
  output logic [BYTES-1:0]     spe_out
);

  localparam int WORDS_ROW = (TOH_COLS + SPE_COLS) * N_STS / BYTES;
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W     = $clog2(WORDS_ROW);

  logic [ROW_W-1:0]      row_now, row_s1;
  logic [COL_W-1:0]      col_now, col_s1;
  logic [8*BYTES-1:0]    data_s1;
  logic                  fp_s1;
  logic [N_STS-1:0][1:0] codes;
  logic [1:0]            warm_q;

  spe_frame_counter #(
    .ROWS(ROWS), .WORDS_ROW(WORDS_ROW), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_counter (
    .clk(clk), .rst(rst), .fp_in(fp_in), .row_now(row_now), .col_now(col_now)
  );

  // Stage 1: word and its position.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_s1 <= '0;
      fp_s1   <= 1'b0;
      row_s1  <= '0;
      col_s1  <= '0;
    end else begin
      data_s1 <= data_in;
      fp_s1   <= fp_in;
      row_s1  <= row_now;
      col_s1  <= col_now;
    end
  end

  spe_ptr_tracker #(
    .N_STS(N_STS), .BYTES(BYTES), .PTR_ROW(PTR_ROW), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_tracker (
    .clk(clk), .rst(rst), .just_en(just_en), .row_i(row_s1), .col_i(col_s1),
    .data_i(data_s1), .codes_o(codes)
  );

  spe_mask_gen #(
    .N_STS(N_STS), .BYTES(BYTES), .PTR_ROW(PTR_ROW), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_mask (
    .clk(clk), .rst(rst), .row_i(row_s1), .col_i(col_s1), .codes_i(codes),
    .mask_o(spe_out)
  );

  // Stage 2: data and pulse leave with the mask.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      fp_out   <= 1'b0;
    end else begin
      data_out <= data_s1;
      fp_out   <= fp_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 1'b1;
  end

  AST_DATA_LAG: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2) |-> (data_out == $past(data_in, 2) &&
                          fp_out == $past(fp_in, 2))); // R4

endmodule

// File: tb/spe_indicator_gen_bench.sv
module spe_indicator_gen_bench;

  localparam int N_STS       = 48;
  localparam int ROWS        = 9;
  localparam int ROW_WORDS   = 1080;
  localparam int FRAME_WORDS = ROWS * ROW_WORDS;

  // Vector: {en[18], sts[17:12], xor_mask[11:2], expected_code[1:0]}
  // code 0 = none, 1 = increment, 2 = decrement
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 6'd0,  10'h2AA, 2'd0},  // R5 disabled: all increment bits flipped
    {1'b1, 6'd47, 10'h2AA, 2'd1},  // R6 five increment bits
    {1'b1, 6'd47, 10'h155, 2'd2},  // R7 vs unchanged history (R8)
    {1'b1, 6'd13, 10'h3FF, 2'd0},  // R8 both groups
    {1'b1, 6'd22, 10'h3E0, 2'd1},  // R6 three inc, two dec
    {1'b1, 6'd22, 10'h014, 2'd0},  // R8 two dec only, history refresh
    {1'b1, 6'd22, 10'h015, 2'd2},  // R7 relative to refreshed history
    {1'b1, 6'd39, 10'h000, 2'd0}   // R8 no change
  };

  logic        clk, rst, just_en, fp_in, fp_out;
  logic [31:0] data_in, data_out;
  logic [3:0]  spe_out;

  spe_indicator_gen u_spe_indicator_gen (
    .clk(clk), .rst(rst), .just_en(just_en), .data_in(data_in), .fp_in(fp_in),
    .data_out(data_out), .fp_out(fp_out), .spe_out(spe_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ptag = "";

  logic [9:0] stored [N_STS];
  logic [9:0] fptr   [N_STS];
  logic [1:0] expc   [N_STS];
  int drow = 0, dcol = 0;
  int mrow = 0, mcol = 0;
  bit armed = 0;
  logic [31:0] h1, h2;
  logic f1, f2;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (row %0d word %0d)", req, act, exp,
               mrow, mcol);
    end
  endtask

  function automatic logic [31:0] gen_word(input int row, input int col);
    logic [31:0] w;
    w = {4'(row), 12'(col), 16'(row * 977 + col * 31)};
    if (row == 3 && col < 12) begin
      for (int b = 0; b < 4; b++)
        w[8*(3-b) +: 8] = {6'b011010, fptr[col*4+b][9:8]};
    end else if (row == 3 && col < 24) begin
      for (int b = 0; b < 4; b++)
        w[8*(3-b) +: 8] = fptr[(col-12)*4+b][7:0];
    end
    return w;
  endfunction

  function automatic logic [3:0] exp_mask(input int row, input int col);
    logic [3:0] m;
    for (int b = 0; b < 4; b++) begin
      if (row == 3 && col >= 24 && col < 36)      m[3-b] = (expc[(col-24)*4+b] == 2'd2);
      else if (row == 3 && col >= 36 && col < 48) m[3-b] = (expc[(col-36)*4+b] != 2'd1);
      else if (col < 36)                          m[3-b] = 1'b0;
      else                                        m[3-b] = 1'b1;
    end
    return m;
  endfunction

  function automatic string tag_of(input int row, input int col);
    if (row == 3 && col >= 24 && col < 48) return {"R9 H3 window R5 R6 R7 R8 ", ptag};
    if (col < 36) return {"R3 overhead R1 ", ptag};
    return {"R3 payload R1 ", ptag};
  endfunction

  always @(posedge clk) begin
    h2 <= h1; h1 <= data_in;
    f2 <= f1; f1 <= fp_in;
  end

  always @(negedge clk) begin
    if (rst) begin
      armed = 0;
    end else begin
      if (fp_out) begin
        mrow = 0; mcol = 0; armed = 1;
      end else if (armed) begin
        mcol++;
        if (mcol == ROW_WORDS) begin
          mcol = 0;
          mrow = (mrow == ROWS - 1) ? 0 : mrow + 1;
        end
      end
      if (armed) begin
        chk(spe_out == exp_mask(mrow, mcol), tag_of(mrow, mcol),
            32'(spe_out), 32'(exp_mask(mrow, mcol)));
        chk(data_out == h2, {"R4 data lag ", ptag}, data_out, h2);
        chk(fp_out == f2, {"R4 pulse lag R2 ", ptag}, 32'(fp_out), 32'(f2));
      end
    end
  end

  task automatic put(input bit fp);
    if (fp) begin drow = 0; dcol = 0; end
    @(posedge clk);
    #1;
    data_in = gen_word(drow, dcol);
    fp_in   = fp;
    dcol++;
    if (dcol == ROW_WORDS) begin
      dcol = 0;
      drow = (drow == ROWS - 1) ? 0 : drow + 1;
    end
  endtask

  task automatic run(input int n, input bit fp_first);
    for (int i = 0; i < n; i++) put(fp_first && i == 0);
  endtask

  task automatic setup(input bit en, input int sts, input logic [9:0] xm,
                       input logic [1:0] code);
    just_en = en;
    for (int s = 0; s < N_STS; s++) begin
      fptr[s] = stored[s];
      expc[s] = 2'd0;
    end
    fptr[sts] = stored[sts] ^ xm;
    expc[sts] = code;
    if (code == 2'd0) stored[sts] = fptr[sts];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N_STS; s++) begin
      stored[s] = 10'(s * 21 + 37);
      fptr[s]   = stored[s];
      expc[s]   = 2'd0;
    end
    rst = 1'b1; just_en = 1'b0; fp_in = 1'b1; data_in = 32'hDEAD_BEEF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(data_out == 32'd0, "R4 reset data", data_out, 32'd0);
    chk(fp_out == 1'b0, "R4 reset pulse", 32'(fp_out), 32'd0);
    chk(spe_out == 4'd0, "R4 reset mask", 32'(spe_out), 32'd0);
    @(posedge clk);
    #1;
    rst = 1'b0; fp_in = 1'b0;

    // Baseline frame fills the pointer history with tracking off.
    setup(1'b0, 0, 10'h000, 2'd0);
    run(FRAME_WORDS, 1'b1);

    for (int v = 0; v < 8; v++) begin
      setup(VEC[v][18], int'(VEC[v][17:12]), VEC[v][11:2], VEC[v][1:0]);
      run(FRAME_WORDS, 1'b1);
    end

    // R2 early pulse: frame cut short in row 5.
    ptag = "R2 early";
    setup(1'b1, 5, 10'h000, 2'd0);
    run(5 * ROW_WORDS + 200, 1'b1);
    setup(1'b1, 20, 10'h2AA, 2'd1);
    run(FRAME_WORDS, 1'b1);

    // R2 late pulse after R1 free wrap of 15 words.
    ptag = "R2 late R1 wrap";
    setup(1'b1, 9, 10'h000, 2'd0);
    run(FRAME_WORDS + 15, 1'b1);
    setup(1'b1, 0, 10'h155, 2'd2);
    run(FRAME_WORDS, 1'b1);
    run(4, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule